// File: doc/BRIEF.md
# Doubly-Linked Queue Insert/Remove Unit

This block keeps circular doubly linked queues in a small word memory that belongs to it. Every element occupies two words. The word at the element's byte address holds the forward link, and the word four bytes above holds the backward link. A queue header is an element like any other: an empty queue is a header whose two links point back at itself. At reset, every 8-byte slot of the memory is such a self-linked element, so any of them can serve as a header or as a free entry.

A caller raises `start` for one cycle with an opcode, an entry address and, for an insert, the address of the element after which the entry goes. The unit then runs the whole pointer rewrite as one uninterruptible sequence, with `busy` high throughout. At the end it pulses `done` together with a result address and four condition flags. All of the flags come from comparing the entry's forward link with its backward link.

The unit validates every address that the operation will touch before it makes any write. If any address fails, the memory is left untouched and the unit signals `fault` instead of reporting flags.

Top module: `qlu_unit`

## Requirements
- R1: After reset, `busy` and `done` are low, and every 8-byte slot at byte address A holds A in both of its words, so each slot is an empty, self-linked queue.
- R2: Opcode 0x0E inserts the entry directly after the predecessor P. With S taken as P's old forward link, the entry's links become S (forward) and P (backward), S's backward link becomes the entry, and P's forward link becomes the entry.
- R3: Opcode 0x0F unlinks the entry E: its predecessor's forward link takes E's forward link, and its successor's backward link takes E's backward link. `result_addr` returns E.
- R4: After an insert, Z is 1 exactly when the entry's two links are equal (the entry was the first in its queue), V is 0, and `result_addr` is 0.
- R5: For both operations, N is the signed less-than and C is the unsigned less-than of the entry's forward link against its backward link. `flags_nzvc` carries N, Z, V, C on bits 3, 2, 1, 0.
- R6: After a remove, Z and V are both 1 exactly when the entry's forward and backward links are equal, meaning nothing was removed or the queue is now empty.
- R7: An address is valid only if it is a multiple of 4 and its element's second word lies inside the memory (address + 4 < memory bytes). An invalid entry, an invalid predecessor on an insert, or an opcode other than 0x0E or 0x0F raises `fault` with flags and result at 0 and changes no memory word.
- R8: A `start` pulse while `busy` is high is ignored. It produces no extra `done` and no memory change.
- R9: `done` is a single-cycle pulse, and `busy` is high from the cycle after `start` is accepted until `done`. Counting from the accepting edge, `done` is high after 8 edges for an insert, after 6 for a remove, and after 2 when the opcode, entry or predecessor is rejected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe, sampled while idle |
| opcode | input | 8 | 0x0E insert, 0x0F remove |
| entry_addr | input | ADDR_W | Byte address of the entry |
| pred_addr | input | ADDR_W | Byte address of the predecessor (insert only) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Address or opcode rejected; valid with done |
| result_addr | output | ADDR_W | Removed entry address, else 0; valid with done |
| flags_nzvc | output | 4 | N, Z, V, C flags; valid with done |

## Verification
The sequencer spends one edge on each link read, one on validation and one on each write. For that reason `done` is due 8 edges after the accepting edge for an insert, 6 for a remove, and 2 for an early rejection. The bench stamps each command with a counter that advances on rising edges and samples outputs on falling edges. It compares the measured distance against the expected figure held in the scoreboard item, so an early or late `done` fails just as a wrong flag does. A reference memory model in the bench mirrors each accepted command, and later removals expose any write that a faulted or ignored command should not have made.

// File: rtl/qlu_pkg.sv
package qlu_pkg;

    localparam logic [7:0] OP_INSERT = 8'h0E;
    localparam logic [7:0] OP_REMOVE = 8'h0F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD1,
        ST_LD2,
        ST_VAL,
        ST_WR,
        ST_DONE
    } seq_state_t;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic opcode_known(input logic [7:0] op);
        return (op == OP_INSERT) || (op == OP_REMOVE);
    endfunction

endpackage

// File: rtl/qlu_link_ram.sv
module qlu_link_ram #(
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W-1:0] rd_data,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ADDR_W-1:0] wr_data
);
    localparam int IDX_W = ADDR_W - 2;

    logic [ADDR_W-1:0] mem [MEM_WORDS];

    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             rd_hit;
    logic             wr_hit;

    assign rd_idx = rd_addr[ADDR_W-1:2];
    assign wr_idx = wr_addr[ADDR_W-1:2];
    assign rd_hit = (rd_addr[1:0] == 2'b00) && (32'(rd_idx) < MEM_WORDS);
    assign wr_hit = (wr_addr[1:0] == 2'b00) && (32'(wr_idx) < MEM_WORDS);

    assign rd_data = rd_hit ? mem[rd_idx] : '0;

    // Reset leaves every two-word slot pointing at its own base address.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) begin
                mem[i] <= ADDR_W'((i / 2) * 8);
            end
        end else if (we && wr_hit) begin
            mem[wr_idx] <= wr_data;
        end
    end

    p_write_aligned_r7: assert property (@(posedge clk) disable iff (rst)
        we |-> (wr_addr[1:0] == 2'b00));

endmodule

// File: rtl/qlu_addr_chk.sv
module qlu_addr_chk #(
    parameter int ADDR_W    = 8,
    parameter int MEM_BYTES = 192
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              ok
);
    logic aligned;
    logic in_range;

    assign aligned  = (addr[1:0] == 2'b00);
    assign in_range = (32'(addr) + 32'd4) < 32'(MEM_BYTES);
    assign ok       = aligned && in_range;

endmodule

// File: rtl/qlu_flag_cmp.sv
module qlu_flag_cmp
    import qlu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] fwd,
    input  logic [ADDR_W-1:0] bwd,
    input  logic              is_remove,
    output flags_t            flags
);
    logic same;

    assign same    = (fwd == bwd);
    assign flags.n = ($signed(fwd) < $signed(bwd));
    assign flags.z = same;
    assign flags.v = is_remove && same;
    assign flags.c = (fwd < bwd);

endmodule

// File: rtl/qlu_seq.sv
module qlu_seq
    import qlu_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [7:0]             opcode,
    input  logic [ADDR_W-1:0]      entry_addr,
    input  logic [ADDR_W-1:0]      pred_addr,
    input  logic [ADDR_W-1:0]      rd_data,
    input  logic [3:0]             addr_ok,
    input  flags_t                 cmp_flags,
    output logic [ADDR_W-1:0]      rd_addr,
    output logic                   we,
    output logic [ADDR_W-1:0]      wr_addr,
    output logic [ADDR_W-1:0]      wr_data,
    output logic [3:0][ADDR_W-1:0] chk_addr,
    output logic [ADDR_W-1:0]      link_fwd,
    output logic [ADDR_W-1:0]      link_bwd,
    output logic                   link_is_rem,
    output logic                   busy,
    output logic                   done,
    output logic                   fault,
    output logic [ADDR_W-1:0]      result,
    output flags_t                 flags
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    seq_state_t        st;
    logic              rem_q;
    logic              op_ok_q;
    logic [ADDR_W-1:0] ent_q;
    logic [ADDR_W-1:0] pred_q;
    logic [ADDR_W-1:0] l1;
    logic [ADDR_W-1:0] l2;
    logic [1:0]        widx;

    logic operands_ok;
    logic links_ok;
    logic last_write;

    // Slot 0: entry, 1: predecessor, 2: first link read, 3: second link.
    assign chk_addr[0] = ent_q;
    assign chk_addr[1] = pred_q;
    assign chk_addr[2] = l1;
    assign chk_addr[3] = l2;

    assign operands_ok = op_ok_q && addr_ok[0] && (rem_q || addr_ok[1]);
    assign links_ok    = addr_ok[2] && addr_ok[3];
    assign last_write  = rem_q ? (widx == 2'd1) : (widx == 2'd3);

    assign link_fwd    = l1;
    assign link_bwd    = l2;
    assign link_is_rem = rem_q;

    assign busy = (st != ST_IDLE);
    assign done = (st == ST_DONE);
    assign we   = (st == ST_WR);

    // A single read port: first link in LD1, backward link in LD2.
    always_comb begin
        if (st == ST_LD2) begin
            rd_addr = ent_q + STEP;
        end else if (rem_q) begin
            rd_addr = ent_q;
        end else begin
            rd_addr = pred_q;
        end
    end

    // Write schedule. Insert: l1 = old successor, l2 = predecessor.
    // Remove: l1 = forward link, l2 = backward link.
    always_comb begin
        wr_addr = ent_q;
        wr_data = l1;
        if (rem_q) begin
            case (widx)
                2'd0:    begin wr_addr = l2;        wr_data = l1; end
                default: begin wr_addr = l1 + STEP; wr_data = l2; end
            endcase
        end else begin
            case (widx)
                2'd0:    begin wr_addr = ent_q;        wr_data = l1;    end
                2'd1:    begin wr_addr = ent_q + STEP; wr_data = l2;    end
                2'd2:    begin wr_addr = l1 + STEP;    wr_data = ent_q; end
                default: begin wr_addr = l2;           wr_data = ent_q; end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            rem_q   <= 1'b0;
            op_ok_q <= 1'b0;
            ent_q   <= '0;
            pred_q  <= '0;
            l1      <= '0;
            l2      <= '0;
            widx    <= '0;
            fault   <= 1'b0;
            result  <= '0;
            flags   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        op_ok_q <= opcode_known(opcode);
                        rem_q   <= (opcode == OP_REMOVE);
                        ent_q   <= entry_addr;
                        pred_q  <= pred_addr;
                        fault   <= 1'b0;
                        result  <= '0;
                        flags   <= '0;
                        st      <= ST_LD1;
                    end
                end
                ST_LD1: begin
                    if (!operands_ok) begin
                        fault <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        l1 <= rd_data;
                        st <= ST_LD2;
                    end
                end
                ST_LD2: begin
                    l2 <= rem_q ? rd_data : pred_q;
                    st <= ST_VAL;
                end
                ST_VAL: begin
                    if (!links_ok) begin
                        fault <= 1'b1;
                        st    <= ST_DONE;
                    end else begin
                        flags  <= cmp_flags;
                        result <= rem_q ? ent_q : '0;
                        widx   <= '0;
                        st     <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (last_write) begin
                        st <= ST_DONE;
                    end else begin
                        widx <= widx + 2'd1;
                    end
                end
                default: begin
                    st <= ST_IDLE;
                end
            endcase
        end
    end

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start) |=> busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_cmd_held_r8: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> ($stable(ent_q) && $stable(pred_q) && $stable(rem_q)));

    p_no_write_on_fault_r7: assert property (@(posedge clk) disable iff (rst)
        ((st == ST_LD1 && !operands_ok) || (st == ST_VAL && !links_ok)) |=> !we);

    p_fault_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (done && fault) |-> (flags == '0 && result == '0));

    p_insert_v_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && !rem_q) |-> (!flags.v && result == '0));

    p_remove_zv_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !fault && rem_q) |-> (flags.z == flags.v && result == ent_q));

endmodule

// File: rtl/qlu_unit.sv
module qlu_unit
    import qlu_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int MEM_WORDS = 48
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [ADDR_W-1:0] entry_addr,
    input  logic [ADDR_W-1:0] pred_addr,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [ADDR_W-1:0] result_addr,
    output logic [3:0]        flags_nzvc
);
    localparam int MEM_BYTES = MEM_WORDS * 4;
    localparam int N_CHK     = 4;

    logic [ADDR_W-1:0]            rd_addr;
    logic [ADDR_W-1:0]            rd_data;
    logic                         we;
    logic [ADDR_W-1:0]            wr_addr;
    logic [ADDR_W-1:0]            wr_data;
    logic [N_CHK-1:0][ADDR_W-1:0] chk_addr;
    logic [N_CHK-1:0]             addr_ok;
    logic [ADDR_W-1:0]            link_fwd;
    logic [ADDR_W-1:0]            link_bwd;
    logic                         link_is_rem;
    flags_t                       cmp_flags;
    flags_t                       flags_q;

    qlu_link_ram #(
        .ADDR_W    (ADDR_W),
        .MEM_WORDS (MEM_WORDS)
    ) u_ram (
        .clk     (clk),
        .rst     (rst),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .we      (we),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    for (genvar g = 0; g < N_CHK; g++) begin : g_chk
        qlu_addr_chk #(
            .ADDR_W    (ADDR_W),
            .MEM_BYTES (MEM_BYTES)
        ) u_chk (
            .addr (chk_addr[g]),
            .ok   (addr_ok[g])
        );
    end

    qlu_flag_cmp #(
        .ADDR_W (ADDR_W)
    ) u_cmp (
        .fwd       (link_fwd),
        .bwd       (link_bwd),
        .is_remove (link_is_rem),
        .flags     (cmp_flags)
    );

    qlu_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .opcode      (opcode),
        .entry_addr  (entry_addr),
        .pred_addr   (pred_addr),
        .rd_data     (rd_data),
        .addr_ok     (addr_ok),
        .cmp_flags   (cmp_flags),
        .rd_addr     (rd_addr),
        .we          (we),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .chk_addr    (chk_addr),
        .link_fwd    (link_fwd),
        .link_bwd    (link_bwd),
        .link_is_rem (link_is_rem),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .result      (result_addr),
        .flags       (flags_q)
    );

    assign flags_nzvc = {flags_q.n, flags_q.z, flags_q.v, flags_q.c};

    p_idle_after_done_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    p_write_only_busy_r8: assert property (@(posedge clk) disable iff (rst)
        we |-> busy);

endmodule

// File: tb/qlu_unit_tb.sv
module qlu_unit_tb;
    localparam int ADDR_W    = 8;
    localparam int MEM_WORDS = 48;
    localparam int MEM_BYTES = MEM_WORDS * 4;

    logic              clk;
    logic              rst;
    logic              start;
    logic [7:0]        opcode;
    logic [ADDR_W-1:0] entry_addr;
    logic [ADDR_W-1:0] pred_addr;
    logic              busy;
    logic              done;
    logic              fault;
    logic [ADDR_W-1:0] result_addr;
    logic [3:0]        flags_nzvc;

    qlu_unit #(.ADDR_W(ADDR_W), .MEM_WORDS(MEM_WORDS)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .opcode      (opcode),
        .entry_addr  (entry_addr),
        .pred_addr   (pred_addr),
        .busy        (busy),
        .done        (done),
        .fault       (fault),
        .result_addr (result_addr),
        .flags_nzvc  (flags_nzvc)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int          lat;
        int          t0;
        bit          flt;
        logic [3:0]  fl;
        logic [7:0]  res;
        string       tag;
    } exp_t;

    exp_t       sb[$];
    int         checks = 0;
    int         fails  = 0;
    int         cyc    = 0;
    logic [7:0] model [MEM_WORDS];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic bit valid(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (int'(a) + 4 < MEM_BYTES);
    endfunction

    function automatic logic [7:0] rd(input logic [7:0] a);
        return model[a >> 2];
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        model[a >> 2] = d;
    endtask

    function automatic logic [3:0] cmp(input logic [7:0] f, input logic [7:0] b,
                                       input bit rem);
        logic n, z, c;
        n = $signed(f) < $signed(b);
        z = (f == b);
        c = f < b;
        return {n, z, rem & z, c};
    endfunction

    // Model-predicted outcome; applies accepted commands to the model memory.
    task automatic predict(input logic [7:0] op, input logic [7:0] e,
                           input logic [7:0] p, output exp_t x);
        logic [7:0] s, f, b;
        x.flt = 1'b0; x.fl = 4'h0; x.res = 8'h00;
        if (!(op == 8'h0E || op == 8'h0F) || !valid(e) || (op == 8'h0E && !valid(p))) begin
            x.flt = 1'b1; x.lat = 2;
        end else if (op == 8'h0E) begin
            s = rd(p);
            if (!valid(s)) begin
                x.flt = 1'b1; x.lat = 4;
            end else begin
                wr(e, s); wr(e + 8'd4, p); wr(s + 8'd4, e); wr(p, e);
                x.fl = cmp(s, p, 1'b0); x.lat = 8;
            end
        end else begin
            f = rd(e); b = rd(e + 8'd4);
            if (!valid(f) || !valid(b)) begin
                x.flt = 1'b1; x.lat = 4;
            end else begin
                wr(b, f); wr(f + 8'd4, b);
                x.fl = cmp(f, b, 1'b1); x.res = e; x.lat = 6;
            end
        end
    endtask

    // Driver: hand < 0 keeps the model's flags, otherwise the hand value is expected.
    task automatic run(input logic [7:0] op, input logic [7:0] e, input logic [7:0] p,
                       input int hand, input string tag, input bit wait_done);
        exp_t x;
        predict(op, e, p, x);
        if (hand >= 0) x.fl = 4'(hand);
        x.tag = tag;
        @(negedge clk);
        start = 1'b1; opcode = op; entry_addr = e; pred_addr = p;
        x.t0 = cyc;
        sb.push_back(x);
        @(negedge clk);
        start = 1'b0;
        chk(busy === 1'b1, "R9", "busy after accept", int'(busy), 1);
        if (wait_done) begin
            while (sb.size() != 0) @(negedge clk);
            @(negedge clk);
        end
    endtask

    // Monitor: pops the scoreboard on each done and compares timing and results.
    always @(negedge clk) begin
        if (!rst && done === 1'b1) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R8", "unexpected done", 1, 0);
            end else begin
                exp_t x;
                x = sb.pop_front();
                chk(cyc - x.t0 == x.lat, x.tag, "done latency", cyc - x.t0, x.lat);
                chk(fault === x.flt, x.tag, "fault", int'(fault), int'(x.flt));
                chk(flags_nzvc === x.fl, x.tag, "flags nzvc", int'(flags_nzvc), int'(x.fl));
                chk(result_addr === x.res, x.tag, "result", int'(result_addr), int'(x.res));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R9", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) model[i] = 8'((i / 2) * 8);
        rst = 1'b1; start = 1'b0; opcode = '0; entry_addr = '0; pred_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(done === 1'b0, "R1", "done after reset", int'(done), 0);

        // R1/R6: header slot is self-linked, so removing it reports empty (Z=V=1).
        run(8'h0F, 8'h00, 8'h00, 4'b0110, "R6", 1'b1);
        // R2/R4: first insert into empty queue sets Z.
        run(8'h0E, 8'h10, 8'h00, 4'b0100, "R4", 1'b1);
        // R5: fwd 0x00 vs bwd 0x10: signed and unsigned both less.
        run(8'h0E, 8'h88, 8'h10, 4'b1001, "R5", 1'b1);
        // R5: fwd 0x00 vs bwd 0x88: unsigned less only (0x88 is negative signed).
        run(8'h0E, 8'h20, 8'h88, 4'b0001, "R5", 1'b1);
        // R2: insert at head of a non-empty queue.
        run(8'h0E, 8'h98, 8'h00, 4'b0000, "R2", 1'b1);
        // R3: unlink from the middle, result is the entry.
        run(8'h0F, 8'h88, 8'h00, 4'b0000, "R3", 1'b1);
        run(8'h0F, 8'h98, 8'h00, 4'b0000, "R3", 1'b1);
        // R7: rejected commands: misaligned entry, predecessor out of range,
        // entry at the top boundary, unknown opcode.
        run(8'h0E, 8'h12, 8'h00, -1, "R7", 1'b1);
        run(8'h0E, 8'h30, 8'hC0, -1, "R7", 1'b1);
        run(8'h0F, 8'hBC, 8'h00, -1, "R7", 1'b1);
        run(8'h05, 8'h30, 8'h20, -1, "R7", 1'b1);
        // R7: last valid slot is accepted.
        run(8'h0F, 8'hB8, 8'h00, 4'b0110, "R7", 1'b1);
        // R8: a second start during the sequence must be dropped.
        run(8'h0E, 8'h30, 8'h20, 4'b1001, "R8", 1'b0);
        start = 1'b1; opcode = 8'h0F; entry_addr = 8'h10;
        @(negedge clk);
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        // R3/R8: the queue is 0x00 -> 0x10 -> 0x20 -> 0x30; 0x10 must still be linked.
        run(8'h0F, 8'h10, 8'h00, 4'b0000, "R8", 1'b1);
        run(8'h0F, 8'h30, 8'h00, 4'b1001, "R3", 1'b1);
        run(8'h0F, 8'h20, 8'h00, 4'b0110, "R6", 1'b1);
        run(8'h0F, 8'h00, 8'h00, 4'b0110, "R6", 1'b1);
        // R2: reuse a freed entry after the last faults; the model tracks links.
        run(8'h0E, 8'h88, 8'h00, -1, "R2", 1'b1);
        run(8'h0E, 8'h10, 8'h88, -1, "R2", 1'b1);
        run(8'h0F, 8'h88, 8'h00, -1, "R3", 1'b1);
        run(8'h0F, 8'h10, 8'h00, 4'b0110, "R6", 1'b1);

        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R9", "pending results", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule